// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the frame clock (LRCK) and the serial bit clock (SCLK) that an audio converter drives when it is the clock master. Both are derived from a single master clock (MCLK). The block does not see MCLK directly. It runs on a system clock at twice the MCLK rate, so every division it performs, including the fractional one-and-a-half step, is a whole number of system cycles.

A 3-bit rate code picks a pre-divider that is applied to MCLK. A 2-bit speed code then picks how the pre-divided clock is split into SCLK and LRCK. In every valid setting a frame holds exactly 64 bit clocks, and the frame clock runs at the sample rate. Codes that are not defined force both clocks low and raise an error flag. Writing any new code value restarts all dividers from a fixed phase.

Top module: `audio_clkgen`

## Requirements
- R1: The rate code gives the pre-divided clock period in system cycles as follows: 000 gives 2 (MCLK ÷1), 001 gives 3 (÷1.5), 010 gives 4 (÷2), 011 gives 6 (÷3) and 100 gives 8 (÷4).
- R2: The speed code divides the pre-divided clock again to form SCLK. Code 00 divides by 4, code 01 by 2 and code 10 by 1. The SCLK period in system cycles is therefore the R1 period times that factor.
- R3: Within each SCLK period, SCLK is first low for the larger half of the period and then high for the smaller half (for an odd period the high part is one cycle shorter). After a restart, the first SCLK period begins low.
- R4: LRCK is high for 32 whole SCLK periods and low for 32. A frame is therefore 64 SCLK periods, which is 256, 128 or 64 pre-divided clock periods for speed codes 00, 01 and 10.
- R5: Apart from a restart, LRCK changes only in a cycle where SCLK goes from high to low.
- R6: With a rate code of 101, 110 or 111, or with speed code 11, SCLK and LRCK are held low and the error flag is high. With valid codes the error flag is low.
- R7: In the cycle after either code input takes a new value, SCLK and LRCK are both low and all dividers begin again from zero.
- R8: While reset is asserted, SCLK, LRCK and the error flag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at twice the MCLK rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code_i | input | 3 | Master-clock pre-divider select |
| speed_code_i | input | 2 | Speed mode select |
| sclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Frame clock at the sample rate |
| cfg_err_o | output | 1 | High while a reserved code is selected |

## Verification
The bench builds the block with its default half-frame length of 32 bit clocks. This is the value that gives 64 bit clocks per frame, so the whole-frame behaviour of every one of the fifteen valid code pairs can be observed within a few thousand cycles each. That includes the longest frame, 2048 cycles at rate ÷4 in single speed, and the odd three-cycle bit clock at rate ÷1.5 in quad speed. Code changes in the middle of a frame and the reserved codes are applied between the sweeps.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Largest pre-divided period (system cycles) and largest speed split
  localparam int PRE_MAX   = 8;
  localparam int SPLIT_MAX = 4;
  localparam int TW        = $clog2(PRE_MAX * SPLIT_MAX);  // bit-phase counter width
  localparam int PW        = TW + 1;                       // width holding a full period

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  typedef struct packed {
    logic [2:0] rate;
    logic [1:0] speed;
  } clk_cfg_t;

  // Pre-divided clock period in system cycles (system clock = 2 x MCLK)
  function automatic logic [3:0] pre_period(input logic [2:0] rate);
    case (rate)
      3'd0:    pre_period = 4'd2;
      3'd1:    pre_period = 4'd3;
      3'd2:    pre_period = 4'd4;
      3'd3:    pre_period = 4'd6;
      3'd4:    pre_period = 4'd8;
      default: pre_period = 4'd0;
    endcase
  endfunction

  // Factor from the pre-divided clock to the bit clock
  function automatic logic [2:0] split_factor(input logic [1:0] speed);
    case (speed_e'(speed))
      SPD_SINGLE: split_factor = 3'd4;
      SPD_DOUBLE: split_factor = 3'd2;
      SPD_QUAD:   split_factor = 3'd1;
      default:    split_factor = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/clkgen_cfg.sv
module clkgen_cfg
  import clkgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    rate_i,
  input  logic [1:0]    speed_i,
  output logic          restart_o,
  output logic          bad_o,
  output logic [PW-1:0] period_o
);

  clk_cfg_t cfg_q;
  clk_cfg_t cfg_d;
  logic [6:0] product;

  // next state: always follow the inputs
  always_comb begin
    cfg_d.rate  = rate_i;
    cfg_d.speed = speed_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign restart_o = (cfg_d != cfg_q);
  assign bad_o     = (cfg_q.rate > 3'd4) || (cfg_q.speed == SPD_RSVD);

  always_comb begin
    product  = 7'(pre_period(cfg_q.rate)) * 7'(split_factor(cfg_q.speed));
    period_o = PW'(product);
  end

  // R6: a legal setting never yields an empty period
  a_r6_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_o |-> (period_o >= PW'(2)));

endmodule

// File: rtl/clkgen_bitdiv.sv
module clkgen_bitdiv
  import clkgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          wrap_o,
  output logic          sclk_o
);

  logic [TW-1:0] phase_q, phase_d;
  logic [PW-1:0] high_from;
  logic          at_end;

  assign at_end    = ({1'b0, phase_q} == period_i - PW'(1));
  assign high_from = period_i - (period_i >> 1);

  always_comb begin
    phase_d = phase_q;
    if (restart_i)  phase_d = '0;
    else if (run_i) phase_d = at_end ? '0 : phase_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign wrap_o = run_i && at_end && !restart_i;
  assign sclk_o = run_i && ({1'b0, phase_q} >= high_from);

  // R2: the phase never reaches the period length
  a_r2_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> ({1'b0, phase_q} < period_i));

  // R3: outside a restart, the bit clock falls only at the start of a period
  a_r3_fall_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && !$past(restart_i)) |-> (phase_q == '0));

endmodule

// File: rtl/clkgen_framediv.sv
module clkgen_framediv #(
  parameter int HALF_SLOTS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic step_i,
  output logic lr_o
);

  localparam int SW = $clog2(HALF_SLOTS);

  logic [SW-1:0] slot_q, slot_d;
  logic          lr_q, lr_d;
  logic          last_slot;

  assign last_slot = (slot_q == SW'(HALF_SLOTS - 1));

  always_comb begin
    slot_d = slot_q;
    lr_d   = lr_q;
    if (restart_i) begin
      slot_d = '0;
      lr_d   = 1'b0;
    end else if (step_i) begin
      slot_d = last_slot ? '0 : slot_q + SW'(1);
      if (last_slot) lr_d = ~lr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      lr_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      lr_q   <= lr_d;
    end
  end

  assign lr_o = lr_q;

  // R4: outside a restart, the frame clock flips only after the last slot
  a_r4_flip_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lr_q) && !$past(restart_i)) |-> ($past(step_i) && slot_q == '0));

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import clkgen_pkg::*;
#(
  parameter int HALF_SLOTS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_code_i,
  input  logic [1:0] speed_code_i,
  output logic       sclk_o,
  output logic       lrck_o,
  output logic       cfg_err_o
);

  logic          restart;
  logic          bad;
  logic [PW-1:0] period;
  logic          wrap;
  logic          sclk_raw;
  logic          lr_raw;

  clkgen_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_i   (rate_code_i),
    .speed_i  (speed_code_i),
    .restart_o(restart),
    .bad_o    (bad),
    .period_o (period)
  );

  clkgen_bitdiv u_bitdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .run_i    (!bad),
    .period_i (period),
    .wrap_o   (wrap),
    .sclk_o   (sclk_raw)
  );

  clkgen_framediv #(.HALF_SLOTS(HALF_SLOTS)) u_framediv (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .step_i   (wrap),
    .lr_o     (lr_raw)
  );

  assign sclk_o    = sclk_raw;
  assign lrck_o    = lr_raw && !bad;
  assign cfg_err_o = bad;

  // R5: the frame clock moves with a falling bit clock, except on restart
  a_r5_lr_on_sclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lrck_o) && !$past(restart)) |-> $fell(sclk_o));

  // R6: a reserved code silences both clocks
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!sclk_o && !lrck_o));

  // R7: a code change restarts from the low phase
  a_r7_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sclk_o && !lrck_o));

endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;

  logic       clk;
  logic       rst_n;
  logic [2:0] rate;
  logic [1:0] speed;
  logic       sclk, lrck, err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmp_en = 0;

  audio_clkgen i_audio_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_code_i (rate),
    .speed_code_i(speed),
    .sclk_o      (sclk),
    .lrck_o      (lrck),
    .cfg_err_o   (err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_rate, m_speed;
  longint m_t;

  function automatic int pre_of(input int r);
    case (r)
      0: return 2; 1: return 3; 2: return 4; 3: return 6; 4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int split_of(input int s);
    case (s)
      0: return 4; 1: return 2; 2: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rate = 0; m_speed = 0; m_t = 0;
    end else if (int'(rate) != m_rate || int'(speed) != m_speed) begin
      m_rate = int'(rate); m_speed = int'(speed); m_t = 0;
    end else begin
      m_t = m_t + 1;
    end
  end

  bit prev_sclk = 0;
  bit prev_lrck = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int per;
      bit ok;
      int e_s, e_l;
      per = pre_of(m_rate) * split_of(m_speed);
      ok  = (per != 0);
      e_s = ok && ((m_t % per) >= (per - per / 2));
      e_l = ok && (((m_t / (32 * per)) % 2) == 1);
      chk("R2 sclk", int'(sclk), e_s);
      chk("R4 lrck", int'(lrck), e_l);
      chk("R6 err", int'(err), int'(!ok));
      if (lrck != prev_lrck && m_t != 0)
        chk("R5 lrck moves on sclk fall", int'(prev_sclk && !sclk), 1);
    end
    prev_sclk = sclk;
    prev_lrck = lrck;
  end

  // ---------------- helpers ----------------
  task automatic set_cfg(input int r, input int s);
    @(negedge clk);
    rate  = 3'(r);
    speed = 2'(s);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // high length and full period of SCLK, sampled on falling edges
  task automatic sclk_profile(output int hi, output int per);
    int lo;
    hi = 0; lo = 0;
    for (int i = 0; i < 100 && sclk !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 100 && sclk !== 1'b1; i++) @(negedge clk);
    for (int i = 0; i < 100 && sclk === 1'b1; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 100 && sclk === 1'b0; i++) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  // LRCK high length in cycles and SCLK rises over one whole frame
  task automatic frame_profile(output int hi_cyc, output int rises);
    bit ps;
    hi_cyc = 0; rises = 0;
    for (int i = 0; i < 5000 && lrck !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 5000 && lrck !== 1'b1; i++) @(negedge clk);
    ps = sclk;
    for (int i = 0; i < 5000 && lrck === 1'b1; i++) begin
      hi_cyc++; @(negedge clk);
      if (sclk && !ps) rises++;
      ps = sclk;
    end
    for (int i = 0; i < 5000 && lrck === 1'b0; i++) begin
      @(negedge clk);
      if (sclk && !ps) rises++;
      ps = sclk;
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int hi, per, fr_hi, fr_rises;
    rate  = 3'd0;
    speed = 2'd0;
    rst_n = 1'b0;
    wait_cycles(3);
    // R8: everything low during reset
    chk("R8 sclk in reset", int'(sclk), 0);
    chk("R8 lrck in reset", int'(lrck), 0);
    chk("R8 err in reset", int'(err), 0);
    rst_n  = 1'b1;
    cmp_en = 1'b1;

    // R1: pre-divider period at quad speed (split of 1)
    for (int r = 0; r < 5; r++) begin
      set_cfg(r, 2);
      sclk_profile(hi, per);
      chk("R1 pre-divided period", per, pre_of(r));
      chk("R3 high part", hi, pre_of(r) / 2);
    end

    // R2: speed split at rate ÷1
    for (int s = 0; s < 3; s++) begin
      set_cfg(0, s);
      sclk_profile(hi, per);
      chk("R2 bit clock period", per, 2 * split_of(s));
    end

    // R3: first bit period after a restart starts low (rate ÷1.5, quad)
    set_cfg(1, 2);
    @(negedge clk);
    chk("R3 low after restart", int'(sclk), 0);
    @(negedge clk);
    chk("R3 still low second cycle", int'(sclk), 0);
    @(negedge clk);
    chk("R3 high third cycle", int'(sclk), 1);

    // full sweep with whole frames; R4 frame shape measured per pair
    for (int r = 0; r < 5; r++) begin
      for (int s = 0; s < 3; s++) begin
        set_cfg(r, s);
        frame_profile(fr_hi, fr_rises);
        chk("R4 lrck high cycles", fr_hi, 32 * pre_of(r) * split_of(s));
        chk("R4 bit clocks per frame", fr_rises, 64);
      end
    end

    // R7: code change in mid frame
    set_cfg(2, 0);
    wait_cycles(700);
    set_cfg(2, 1);
    @(negedge clk);
    chk("R7 sclk after change", int'(sclk), 0);
    chk("R7 lrck after change", int'(lrck), 0);
    wait_cycles(300);
    set_cfg(3, 1);
    @(negedge clk);
    chk("R7 lrck after rate change", int'(lrck), 0);
    wait_cycles(500);

    // R6: reserved codes
    for (int r = 5; r < 8; r++) begin
      set_cfg(r, 0);
      wait_cycles(20);
      chk("R6 err for reserved rate", int'(err), 1);
      chk("R6 sclk quiet", int'(sclk), 0);
    end
    set_cfg(0, 3);
    wait_cycles(20);
    chk("R6 err for reserved speed", int'(err), 1);
    chk("R6 lrck quiet", int'(lrck), 0);
    set_cfg(0, 2);
    wait_cycles(300);
    chk("R6 err cleared", int'(err), 0);

    cmp_en = 1'b0;
    done   = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule